// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Selectable Read Mode

This block moves bytes from one clock domain to another. Both clocks run freely. A byte is taken in only on a rising write-clock edge where the write valid input is high and the FIFO is not full. On the read side the consumer raises a ready input to take the next byte, and an empty flag reports when nothing is waiting. Each side keeps its own binary and Gray-coded pointer. The Gray pointers cross to the other side through a chain of synchronizing flops. Each side then works out its own flag from its local pointer and the pointer it received.

A parameter sets the read mode. In registered mode, a read that is accepted loads the oldest byte into an output register, and that register keeps its value until the next accepted read. In show-ahead mode, the oldest byte is already on the output whenever the FIFO is not empty. A high ready input then acknowledges that byte and brings the next one forward.

Back-pressure works as follows. On the write side, valid is the request and the inverse of the full flag is the ready. A byte offered while full is dropped and is not kept pending. On the read side, the inverse of the empty flag is the valid and the ready input is the request or acknowledge. A ready seen while empty does nothing.

Top module: `byte_cdc_fifo`

## Requirements
- R1: While either reset is low and after it is released, the read side shows empty high, the write side shows full low, and in registered mode the output reads 8'h00.
- R2: A byte is stored only on a rising write-clock edge with the write valid high and full low. With no reads, exactly DEPTH (default 16) bytes are accepted before full goes high.
- R3: A write offered while full is ignored: it does not move the write pointer and the byte never appears at the output.
- R4: A read ready seen while empty is ignored: the read pointer stays put and the registered output keeps its value.
- R5: Every accepted byte is delivered exactly once and in write order. A stream of 256 accepted bytes gives exactly 256 delivered bytes.
- R6: Empty is low whenever an undelivered byte is visible to the read side. It goes high only after the last stored byte has been delivered, and it is never low while nothing is stored.
- R7: In show-ahead mode, whenever empty is low the output holds the oldest undelivered byte. A read-clock edge with ready high and empty low moves the next byte onto the output.
- R8: In registered mode, the output changes only on a read-clock edge where ready is high and empty is low. After that edge it holds the byte just read until the next such edge.
- R9: After a byte is written into an empty FIFO, empty goes low within four read-clock rising edges.
- R10: Each Gray pointer changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock, free running |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_valid | input | 1 | Write request; sampled on wr_clk |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | No room; the inverse is the write ready |
| rd_clk | input | 1 | Read-side clock, free running |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_ready | input | 1 | Read request (registered mode) or acknowledge (show-ahead mode) |
| rd_data | output | 8 | Output byte |
| rd_empty | output | 1 | Nothing to read; the inverse is the read valid |

## Verification
A write and a read can land in the same stretch of time. The hard cases are the last write arriving while the reader drains the FIFO to empty, and a read freeing a slot just as the writer meets full. The bench provokes both by driving random valid and ready on two clocks with unrelated periods, over a 256-byte stream, next to a directed fill past full and a directed drain past empty. Both read-mode variants run side by side on the same stimulus. Each output byte is compared with a bench queue in the cycle the mode defines, so a lost, duplicated or early byte shows up at once.

// File: rtl/bcf_pkg.sv
package bcf_pkg;
  typedef enum logic {
    RD_REGISTERED = 1'b0,
    RD_SHOW_AHEAD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/bcf_sync.sv
module bcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/bcf_mem.sv
module bcf_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] arr [WORDS];

  always_ff @(posedge wclk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/bcf_wr_side.sv
module bcf_wr_side #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [PTR_W-1:0] rd_gray_sync,
  output logic             full,
  output logic             wr_en,
  output logic [PTR_W-2:0] addr,
  output logic [PTR_W-1:0] gray_q
);
  logic [PTR_W-1:0] bin_q, bin_nxt;

  assign bin_nxt = bin_q + 1'b1;
  assign wr_en   = wr_valid && !full;
  assign addr    = bin_q[PTR_W-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (wr_en) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  // full: top two bits opposite, the rest equal
  assign full = (gray_q == {~rd_gray_sync[PTR_W-1:PTR_W-2], rd_gray_sync[PTR_W-3:0]});

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full) |=> $stable(gray_q));

  assert_gray_step_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  assert_write_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !full) |=> (bin_q == $past(bin_q) + 1'b1));
endmodule

// File: rtl/bcf_rd_side.sv
module bcf_rd_side
  import bcf_pkg::*;
#(
  parameter int       PTR_W = 5,
  parameter int       DW    = 8,
  parameter rd_mode_e MODE  = RD_REGISTERED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ready,
  input  logic [PTR_W-1:0] wr_gray_sync,
  input  logic [DW-1:0]    mem_rdata,
  output logic             empty,
  output logic [PTR_W-2:0] addr,
  output logic [PTR_W-1:0] gray_q,
  output logic [DW-1:0]    rd_data
);
  logic [PTR_W-1:0] bin_q, bin_nxt;
  logic             rd_en;

  assign bin_nxt = bin_q + 1'b1;
  assign empty   = (gray_q == wr_gray_sync);
  assign rd_en   = rd_ready && !empty;
  assign addr    = bin_q[PTR_W-2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (rd_en) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  generate
    if (MODE == RD_SHOW_AHEAD) begin : g_ahead
      // head slot is stable while not empty; drive it straight out
      assign rd_data = mem_rdata;
    end else begin : g_reg
      logic [DW-1:0] out_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     out_q <= '0;
        else if (rd_en) out_q <= mem_rdata;
      end
      assign rd_data = out_q;

      assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ready && !empty) |=> $stable(rd_data));
    end
  endgenerate

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && empty) |=> $stable(bin_q));

  assert_gray_step_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/byte_cdc_fifo.sv
module byte_cdc_fifo
  import bcf_pkg::*;
#(
  parameter int       DATA_W      = 8,
  parameter int       DEPTH       = 16,
  parameter int       SYNC_STAGES = 2,
  parameter rd_mode_e RD_MODE     = RD_REGISTERED
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_at_rd, rd_gray_at_wr;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              wr_en;

  bcf_wr_side #(.PTR_W(PTR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid),
    .rd_gray_sync(rd_gray_at_wr), .full(wr_full), .wr_en(wr_en),
    .addr(wr_addr), .gray_q(wr_gray)
  );

  bcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_at_rd)
  );

  bcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_sync_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_gray), .q(rd_gray_at_wr)
  );

  bcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  bcf_rd_side #(.PTR_W(PTR_W), .DW(DATA_W), .MODE(RD_MODE)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .rd_ready(rd_ready),
    .wr_gray_sync(wr_gray_at_rd), .mem_rdata(mem_rdata), .empty(rd_empty),
    .addr(rd_addr), .gray_q(rd_gray), .rd_data(rd_data)
  );
endmodule

// File: tb/byte_cdc_fifo_tb.sv
module byte_cdc_fifo_tb;
  import bcf_pkg::*;
  localparam int DEPTH = 16;

  logic wr_clk = 0, rd_clk = 0;
  always #10 wr_clk = ~wr_clk;  // 50 MHz
  always #17 rd_clk = ~rd_clk;

  logic       wr_rst_n, rd_rst_n, wr_valid, rd_ready;
  logic [7:0] wr_data;
  logic       full_r, full_a, empty_r, empty_a;
  logic [7:0] data_r, data_a;

  byte_cdc_fifo #(.DEPTH(DEPTH), .RD_MODE(RD_REGISTERED)) u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(full_r), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready),
    .rd_data(data_r), .rd_empty(empty_r));

  byte_cdc_fifo #(.DEPTH(DEPTH), .RD_MODE(RD_SHOW_AHEAD)) u_dut_ahead (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(full_a), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ready(rd_ready),
    .rd_data(data_a), .rd_empty(empty_a));

  int n_chk = 0, n_fail = 0;
  logic [7:0] q[$];
  int  rd_mode = 0;  // 0 none, 1 random, 2 always
  bit  mon_on = 0, pop_prev = 0;
  logic [7:0] last_pop = 0, hold_r = 0;
  int  rd_count = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // read-side driver and checker, sampled mid-cycle
  always @(negedge rd_clk) if (mon_on) begin
    bit pop;
    if (pop_prev) check(data_r == last_pop, "R8/R5 registered output", data_r, last_pop);
    else          check(data_r == hold_r, rd_ready ? "R4 read while empty" : "R8 hold", data_r, hold_r);
    hold_r = data_r;
    check(empty_a == empty_r, "R6 modes agree on empty", empty_a, empty_r);
    if (!empty_a) begin
      check(q.size() > 0, "R6 empty low with nothing stored", q.size(), 1);
      if (q.size() > 0) check(data_a == q[0], "R7 show-ahead head", data_a, q[0]);
    end
    case (rd_mode)
      1:       rd_ready = ($urandom % 2) == 0;
      2:       rd_ready = 1'b1;
      default: rd_ready = 1'b0;
    endcase
    pop = rd_ready && !empty_r;
    if (pop && q.size() > 0) begin
      last_pop = q.pop_front();
      rd_count++;
    end
    pop_prev = pop;
  end

  task automatic push(input logic [7:0] d, input bit v, output bit acc);
    @(negedge wr_clk);
    wr_valid = v;
    wr_data  = d;
    acc = v && !full_r;
    @(posedge wr_clk);
    #1;
    if (acc) q.push_back(d);
  endtask

  task automatic drain();
    rd_mode = 2;
    wait (q.size() == 0);
    repeat (8) @(negedge rd_clk);
    check(empty_r == 1'b1, "R6 empty after last delivery", empty_r, 1);
    rd_mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    bit acc;
    int n, acc_cnt, total;
    void'($urandom(32'd20240611));
    wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; wr_data = 0; rd_ready = 0;
    repeat (3) @(negedge wr_clk);
    check(empty_r == 1 && empty_a == 1, "R1 empty in reset", empty_r, 1);
    check(full_r == 0, "R1 full low in reset", full_r, 0);
    repeat (2) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (3) @(negedge rd_clk);
    check(empty_r == 1, "R1 empty after reset", empty_r, 1);
    check(full_r == 0, "R1 full after reset", full_r, 0);
    check(data_r == 8'h00, "R1 registered output after reset", data_r, 0);
    mon_on = 1;

    // R9: first byte latency into an empty FIFO
    push(8'h5A, 1'b1, acc);
    @(negedge wr_clk); wr_valid = 0;
    n = 0;
    while (empty_r && n < 10) begin @(negedge rd_clk); n++; end
    check(n <= 4, "R9 first byte latency", n, 4);
    drain();

    // R2/R3: fill with no reads, then push into full
    acc_cnt = 0; n = 0;
    while (!full_r && n < 40) begin
      push(8'h10 + 8'(n), 1'b1, acc);
      if (acc) acc_cnt++;
      n++;
    end
    check(acc_cnt == DEPTH, "R2 accepted before full", acc_cnt, DEPTH);
    for (int i = 0; i < 5; i++) begin
      push(8'hEE, 1'b1, acc);
      check(acc == 0 && full_r == 1, "R3 write while full", acc, 0);
    end
    @(negedge wr_clk); wr_valid = 0;
    repeat (6) @(negedge rd_clk);
    check(q.size() == DEPTH, "R3 stored count", q.size(), DEPTH);
    rd_count = 0;
    drain();
    check(rd_count == DEPTH, "R3/R5 drained count", rd_count, DEPTH);

    // R4: read requests on an empty FIFO for a while
    rd_mode = 2;
    repeat (10) @(negedge rd_clk);
    check(empty_r == 1 && q.size() == 0, "R4 still empty", empty_r, 1);
    rd_mode = 0;

    // R5: 256-byte random stream with concurrent random reads
    rd_count = 0; total = 0;
    rd_mode = 1;
    while (total < 256) begin
      push(8'($urandom), ($urandom % 10) < 7, acc);
      if (acc) total++;
    end
    @(negedge wr_clk); wr_valid = 0;
    drain();
    check(rd_count == 256, "R5 stream count", rd_count, 256);
    check(full_r == 0, "R2 full clear when drained", full_r, 0);

    mon_on = 0;
    repeat (4) @(negedge wr_clk);
    summary();
    $finish;
  end
endmodule